// File: doc/BRIEF.md
# Page-Mode External Memory Cycle Sequencer

This block converts requests from an internal bus master into timed cycles on an external asynchronous memory bus. It drives an active-low chip select, separate active-low read and write strobes, a word address, write data and a write-data output enable. A single request can cover a burst of one or more consecutive words. The first word of a burst uses the normal access timing. Each later word uses a shorter page wait count. Chip select stays asserted from the first word to the last.

Timing comes from six static settings, each 3 bits wide: chip-select setup, strobe setup, first-access wait, page wait, write-data hold delay and chip-select release delay. A setting of zero removes that phase completely. On the internal side, the requester holds `req` high with the address, direction and beat count. `ack` pulses once for each word, in the cycle whose closing edge takes the current `req_wdata`. Read words come back on `rdata`, each marked by a one-cycle `rvalid` pulse.

Top module: `page_bus_seq`

## Requirements
- R1: While reset is high and on the cycle after it is released: `cs_n`, `rd_n` and `wr_n` are high, and `bus_wde`, `ack` and `rvalid` are low.
- R2: Each burst begins with one start cycle. In that cycle `ack` is high and `cs_n` is still high. `cs_n` falls on the next cycle and never falls at any other point.
- R3: For a one-word burst, `cs_n` stays low for cs_setup + strobe_setup + wait_first + 1 cycles, plus 1 extra cycle for a read or wd_delay cycles for a write.
- R4: `cs_n` stays low as one unbroken run over the whole burst. Each word after the first adds strobe_setup + page_wait + 1 cycles to that run, plus wd_delay cycles for a write. A strobe is only ever low while `cs_n` is low.
- R5: When strobe_setup is nonzero, the active strobe goes high after each word's wait-end cycle and falls again once per word. When strobe_setup is zero, the strobe falls exactly once per burst and stays low between words, including through write-data delay cycles that are not the last. `rd_n` and `wr_n` are never low together.
- R6: In a write burst, wd_delay cycles are inserted after every word's wait-end cycle, including the last. They delay the next word's start and lengthen the chip-select run.
- R7: A read burst has no sample cycle between words. It has exactly one extra chip-select cycle after the last word. `rvalid` pulses once per word, one cycle after that word's wait-end cycle, with `rdata` equal to `bus_rdata` as sampled at the end of the wait-end cycle. `wr_n` stays high while `rvalid` is high.
- R8: The word address starts at `req_addr` and increases by one for each later word, then holds its last value after the burst. While `wr_n` is low, `bus_wdata` carries the data taken by that word's `ack` and `bus_wde` is high.
- R9: After the chip-select run ends, `cs_n` stays high for cs_release + 2 cycles before the next burst's run, when `req` is held high: cs_release delay cycles, one idle cycle and the start cycle.
- R10: In a write burst, `bus_wde` is high for exactly the cycles in which `cs_n` is low. It is never high in a read burst.
- R11: `req_beats` encodes the burst length minus one. `ack` pulses exactly that number plus one times per burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cs_setup | input | 3 | Chip-select setup cycles before the strobe phase of the first word |
| cfg_strb_setup | input | 3 | Strobe setup cycles before each word's wait |
| cfg_wait_first | input | 3 | Wait cycles of the first word before its wait-end cycle |
| cfg_wait_page | input | 3 | Wait cycles of each later word before its wait-end cycle |
| cfg_wd_delay | input | 3 | Write-data hold cycles after each written word |
| cfg_cs_release | input | 3 | Chip-select-high cycles after a burst before the next request |
| req | input | 1 | Request, held high until the last `ack` |
| req_we | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | 16 | Word address of the first word |
| req_beats | input | 3 | Burst length minus one |
| req_wdata | input | 16 | Write data for the word that the next `ack` takes |
| ack | output | 1 | One pulse per word; `req_wdata` is taken at the end of that cycle |
| rdata | output | 16 | Read word |
| rvalid | output | 1 | One-cycle marker for `rdata` |
| cs_n | output | 1 | Chip select, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| bus_addr | output | 16 | External word address |
| bus_wdata | output | 16 | External write data |
| bus_wde | output | 1 | Write-data output enable |
| bus_rdata | input | 16 | External read data |

## Verification
The bench uses the default parameters: 16-bit address and data, 3-bit setting fields and bursts of up to eight words. With 3-bit settings, every phase can be set to zero. That covers the tightest case, in which the wait-end cycle of one word runs straight into the next, as well as multi-cycle setup, wait and delay phases in the same run. The vectors mix strobe setup of zero and nonzero with write-data delay of zero and nonzero, so both the held-strobe and re-pulsed-strobe cases appear for reads and writes. Back-to-back bursts with the request held high bring the release gap within reach of a direct measurement.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

    localparam int CFG_W = 3;

    typedef enum logic [3:0] {
        S_IDLE, S_TS, S_CSA, S_ASW, S_WT, S_END, S_DLY, S_RDS, S_NEG
    } phase_e;

    typedef struct packed {
        logic [CFG_W-1:0] cs_setup;
        logic [CFG_W-1:0] strb_setup;
        logic [CFG_W-1:0] wait_first;
        logic [CFG_W-1:0] wait_page;
        logic [CFG_W-1:0] wd_delay;
        logic [CFG_W-1:0] cs_release;
    } timing_t;

    // first phase of a page word after the previous word has closed
    function automatic phase_e page_entry(timing_t t);
        if (t.strb_setup != '0)     return S_ASW;
        else if (t.wait_page != '0) return S_WT;
        else                        return S_END;
    endfunction

    function automatic phase_e burst_tail(timing_t t);
        return (t.cs_release != '0) ? S_NEG : S_IDLE;
    endfunction

    function automatic logic [CFG_W-1:0] phase_len(phase_e p, timing_t t, logic first);
        case (p)
            S_CSA:   return t.cs_setup;
            S_ASW:   return t.strb_setup;
            S_WT:    return first ? t.wait_first : t.wait_page;
            S_DLY:   return t.wd_delay;
            S_NEG:   return t.cs_release;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/pbs_fsm.sv
module pbs_fsm
    import pbs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    req,
    input  timing_t tcfg,
    input  logic    is_wr,
    input  logic    last,
    output phase_e  ph,
    output logic    adv_beat
);

    logic [CFG_W-1:0] cnt;
    logic             first;
    logic             nfirst;
    logic             counted;
    logic             done;
    logic             wr_hold;
    phase_e           ns;

    assign wr_hold = is_wr && (tcfg.wd_delay != '0);

    always_comb begin
        counted  = (ph == S_CSA) || (ph == S_ASW) || (ph == S_WT) ||
                   (ph == S_DLY) || (ph == S_NEG);
        done     = (ph == S_IDLE) ? req : (counted ? (cnt == '0) : 1'b1);
        adv_beat = done && !last &&
                   (((ph == S_END) && !wr_hold) || (ph == S_DLY));
        nfirst   = (ph == S_TS) ? 1'b1 : (adv_beat ? 1'b0 : first);
        ns       = ph;
        case (ph)
            S_IDLE: ns = S_TS;
            S_TS: begin
                if (tcfg.cs_setup != '0)         ns = S_CSA;
                else if (tcfg.strb_setup != '0)  ns = S_ASW;
                else if (tcfg.wait_first != '0)  ns = S_WT;
                else                             ns = S_END;
            end
            S_CSA: begin
                if (tcfg.strb_setup != '0)       ns = S_ASW;
                else if (tcfg.wait_first != '0)  ns = S_WT;
                else                             ns = S_END;
            end
            S_ASW: ns = ((first ? tcfg.wait_first : tcfg.wait_page) != '0) ? S_WT : S_END;
            S_WT:  ns = S_END;
            S_END: begin
                if (wr_hold)      ns = S_DLY;
                else if (!last)   ns = page_entry(tcfg);
                else if (is_wr)   ns = burst_tail(tcfg);
                else              ns = S_RDS;
            end
            S_DLY: ns = last ? burst_tail(tcfg) : page_entry(tcfg);
            S_RDS: ns = burst_tail(tcfg);
            S_NEG: ns = S_IDLE;
            default: ns = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph    <= S_IDLE;
            cnt   <= '0;
            first <= 1'b0;
        end else begin
            first <= nfirst;
            if (done) begin
                ph  <= ns;
                cnt <= phase_len(ns, tcfg, nfirst) - 1'b1;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // R2: the start cycle is always entered from idle
    p_ts_from_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (ph == S_TS) |-> ($past(ph) == S_IDLE));

    // R9: the release phase always hands over to idle, never straight to a new start
    p_neg_to_idle_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(ph) == S_NEG) && (ph != S_NEG) |-> (ph == S_IDLE));

endmodule

// File: rtl/pbs_datapath.sv
module pbs_datapath
    import pbs_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int BW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  phase_e        ph,
    input  logic          adv_beat,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [BW-1:0] req_beats,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] bus_rdata,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata,
    output logic          is_wr,
    output logic          last,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);

    localparam logic [AW-1:0] ADDR_STEP = AW'(1);

    logic [BW-1:0] beats_left;

    assign last = (beats_left == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr       <= '0;
            wdata      <= '0;
            is_wr      <= 1'b0;
            beats_left <= '0;
            rdata      <= '0;
            rvalid     <= 1'b0;
        end else begin
            if (ph == S_TS) begin
                addr       <= req_addr;
                wdata      <= req_wdata;
                is_wr      <= req_we;
                beats_left <= req_beats;
            end else if (adv_beat) begin
                addr       <= addr + ADDR_STEP;
                wdata      <= req_wdata;
                beats_left <= beats_left - 1'b1;
            end
            rvalid <= (ph == S_END) && !is_wr;
            if ((ph == S_END) && !is_wr)
                rdata <= bus_rdata;
        end
    end

    // R8: every advance to a later word steps the address by one
    p_addr_step_r8: assert property (@(posedge clk) disable iff (rst)
        adv_beat |=> (addr == $past(addr) + ADDR_STEP));

    // R11: the word count never wraps inside a burst
    p_beats_nowrap_r11: assert property (@(posedge clk) disable iff (rst)
        adv_beat |-> (beats_left != '0));

endmodule

// File: rtl/page_bus_seq.sv
module page_bus_seq
    import pbs_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int BW = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CFG_W-1:0] cfg_cs_setup,
    input  logic [CFG_W-1:0] cfg_strb_setup,
    input  logic [CFG_W-1:0] cfg_wait_first,
    input  logic [CFG_W-1:0] cfg_wait_page,
    input  logic [CFG_W-1:0] cfg_wd_delay,
    input  logic [CFG_W-1:0] cfg_cs_release,
    input  logic             req,
    input  logic             req_we,
    input  logic [AW-1:0]    req_addr,
    input  logic [BW-1:0]    req_beats,
    input  logic [DW-1:0]    req_wdata,
    output logic             ack,
    output logic [DW-1:0]    rdata,
    output logic             rvalid,
    output logic             cs_n,
    output logic             rd_n,
    output logic             wr_n,
    output logic [AW-1:0]    bus_addr,
    output logic [DW-1:0]    bus_wdata,
    output logic             bus_wde,
    input  logic [DW-1:0]    bus_rdata
);

    timing_t tcfg;
    phase_e  ph;
    logic    adv_beat;
    logic    is_wr;
    logic    last;
    logic    strobe_on;

    assign tcfg = '{cs_setup:   cfg_cs_setup,
                    strb_setup: cfg_strb_setup,
                    wait_first: cfg_wait_first,
                    wait_page:  cfg_wait_page,
                    wd_delay:   cfg_wd_delay,
                    cs_release: cfg_cs_release};

    pbs_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .tcfg     (tcfg),
        .is_wr    (is_wr),
        .last     (last),
        .ph       (ph),
        .adv_beat (adv_beat)
    );

    pbs_datapath #(.AW(AW), .DW(DW), .BW(BW)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .ph        (ph),
        .adv_beat  (adv_beat),
        .req_we    (req_we),
        .req_addr  (req_addr),
        .req_beats (req_beats),
        .req_wdata (req_wdata),
        .bus_rdata (bus_rdata),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .is_wr     (is_wr),
        .last      (last),
        .rdata     (rdata),
        .rvalid    (rvalid)
    );

    always_comb begin
        strobe_on = (ph == S_WT) || (ph == S_END) ||
                    ((ph == S_DLY) && (tcfg.strb_setup == '0) && !last);
        cs_n      = (ph == S_IDLE) || (ph == S_TS) || (ph == S_NEG);
        rd_n      = !(strobe_on && !is_wr);
        wr_n      = !(strobe_on && is_wr);
        bus_wde   = is_wr && ((ph == S_CSA) || (ph == S_ASW) || (ph == S_WT) ||
                              (ph == S_END) || (ph == S_DLY));
        ack       = (ph == S_TS) || adv_beat;
    end

    // R4: strobes only while selected
    p_strb_in_cs_r4: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n) |-> !cs_n);

    // R5: read and write strobes exclusive
    p_strb_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));

    // R10: data drive only inside the select window
    p_wde_in_cs_r10: assert property (@(posedge clk) disable iff (rst)
        bus_wde |-> !cs_n);

    // R2: select falls only right after the start cycle
    p_cs_fall_start_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> $past(ack));

    // R7: returned read data never coincides with a write strobe
    p_rvalid_read_r7: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> wr_n);

endmodule

// File: tb/sim_page_bus_seq.sv
`timescale 1ns/1ps
module sim_page_bus_seq;

    localparam int AW = 16;
    localparam int DW = 16;
    localparam int BW = 3;
    localparam int NV = 7;

    // {we, beats-1, cs_setup, strb_setup, wait_first, wait_page, wd_delay, cs_release}
    localparam logic [21:0] VEC [NV] = '{
        {1'b0, 3'd3, 3'd1, 3'd1, 3'd2, 3'd1, 3'd0, 3'd1},
        {1'b0, 3'd2, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0},
        {1'b1, 3'd3, 3'd1, 3'd0, 3'd2, 3'd1, 3'd0, 3'd2},
        {1'b1, 3'd2, 3'd0, 3'd2, 3'd1, 3'd0, 3'd2, 3'd1},
        {1'b1, 3'd1, 3'd2, 3'd0, 3'd3, 3'd2, 3'd3, 3'd0},
        {1'b0, 3'd0, 3'd0, 3'd3, 3'd4, 3'd0, 3'd0, 3'd2},
        {1'b1, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] c_cs = '0, c_as = '0, c_w1 = '0, c_pw = '0, c_dd = '0, c_neg = '0;
    logic req = 1'b0, req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [BW-1:0] req_beats = '0;
    logic [DW-1:0] req_wdata = '0;
    logic ack, rvalid, cs_n, rd_n, wr_n, bus_wde;
    logic [DW-1:0] rdata, bus_wdata, bus_rdata;
    logic [AW-1:0] bus_addr;

    int total = 0, bad = 0, cyc = 0;
    int n_cs, n_stb, n_fall, n_wde, n_rv, n_dbad, gap, last_gap;
    logic prev_stb, prev_cs;
    logic [AW-1:0] base;

    always #2 clk = ~clk;

    assign bus_rdata = bus_addr ^ 16'h5A5A;

    page_bus_seq #(.AW(AW), .DW(DW), .BW(BW)) u0 (
        .clk(clk), .rst(rst),
        .cfg_cs_setup(c_cs), .cfg_strb_setup(c_as), .cfg_wait_first(c_w1),
        .cfg_wait_page(c_pw), .cfg_wd_delay(c_dd), .cfg_cs_release(c_neg),
        .req(req), .req_we(req_we), .req_addr(req_addr), .req_beats(req_beats),
        .req_wdata(req_wdata), .ack(ack), .rdata(rdata), .rvalid(rvalid),
        .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wde(bus_wde), .bus_rdata(bus_rdata)
    );

    function automatic logic [DW-1:0] wpat(logic [AW-1:0] a);
        return DW'(a * 3) + 16'h1234;
    endfunction

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            finish_run();
        end
    end

    // bus monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (!rst) begin
            if (!cs_n) n_cs++;
            if (!rd_n || !wr_n) n_stb++;
            if ((!rd_n || !wr_n) && prev_stb) n_fall++;
            if (bus_wde) n_wde++;
            if (!wr_n && (bus_wdata != wpat(bus_addr) || !bus_wde)) n_dbad++;
            if (rvalid) begin
                if (rdata != ((base + AW'(n_rv)) ^ 16'h5A5A)) n_dbad++;
                n_rv++;
            end
            if (cs_n) gap++;
            if (!cs_n && prev_cs) last_gap = gap;
            if (!cs_n) gap = 0;
        end
        prev_stb = rd_n && wr_n;
        prev_cs  = cs_n;
    end

    task automatic clear_meas();
        n_cs = 0; n_stb = 0; n_fall = 0; n_wde = 0; n_rv = 0; n_dbad = 0;
    endtask

    // drive one burst; hold keeps req high for an immediate follow-on
    task automatic burst(input bit we, input int beats, input logic [AW-1:0] a0,
                         input bit hold, output int acks, output int cs_at_first);
        int guard = 0;
        acks = 0; cs_at_first = 0;
        @(negedge clk);
        req = 1'b1; req_we = we; req_addr = a0; req_beats = BW'(beats - 1);
        req_wdata = wpat(a0);
        while (acks < beats && guard < 300) begin
            @(negedge clk);
            guard++;
            if (ack) begin
                if (acks == 0) cs_at_first = int'(cs_n);
                acks++;
                @(posedge clk); #1;
                if (acks == beats) begin
                    if (!hold) req = 1'b0;
                end else begin
                    req_wdata = wpat(a0 + AW'(acks));
                end
            end
        end
    endtask

    initial begin
        int acks, csf, b, we, ecs, estb, efall;
        clear_meas(); gap = 0; last_gap = 0; base = '0;
        prev_stb = 1'b0; prev_cs = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(cs_n && rd_n && wr_n && !bus_wde && !ack && !rvalid, "R1 reset", 0, 0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check(cs_n && rd_n && wr_n && !bus_wde && !ack && !rvalid, "R1 after reset", 0, 0);

        for (int i = 0; i < NV; i++) begin
            {we, b, c_cs, c_as, c_w1, c_pw, c_dd, c_neg} = {31'd0, VEC[i][21], 29'd0,
                VEC[i][20:18], VEC[i][17:0]} ;
            b = b + 1;
            base = AW'(16'h0100 * (i + 1));
            clear_meas();
            burst(we[0], b, base, 1'b0, acks, csf);
            repeat (30) @(negedge clk);
            ecs  = c_cs + c_as + c_w1 + 1 + (b - 1) * (c_as + c_pw + 1) +
                   (we != 0 ? b * c_dd : 1);
            estb = c_w1 + 1 + (b - 1) * (c_pw + 1) +
                   ((we != 0 && c_as == 0) ? (b - 1) * c_dd : 0);
            efall = (c_as != 0) ? b : 1;
            check(csf == 1, "R2 start cycle cs high", csf, 1);
            check(acks == b, "R11 ack count", acks, b);
            check(n_cs == ecs, (b == 1) ? "R3 single cs window" : "R4 R6 burst cs window", n_cs, ecs);
            check(n_fall == efall, "R5 strobe falls", n_fall, efall);
            check(n_stb == estb, "R5 strobe low cycles", n_stb, estb);
            check(n_dbad == 0, "R7 R8 data on bus", n_dbad, 0);
            check(bus_addr == base + AW'(b - 1), "R8 final address", int'(bus_addr), int'(base) + b - 1);
            if (we != 0) begin
                check(n_wde == ecs, "R10 wde window", n_wde, ecs);
            end else begin
                check(n_wde == 0, "R10 no wde on read", n_wde, 0);
                check(n_rv == b, "R7 rvalid per word", n_rv, b);
            end
        end

        // R9: back-to-back bursts with release delay 3 and 0
        for (int k = 0; k < 2; k++) begin
            c_cs = 3'd1; c_as = 3'd0; c_w1 = 3'd1; c_pw = 3'd0; c_dd = 3'd0;
            c_neg = (k == 0) ? 3'd3 : 3'd0;
            base = 16'h0800;
            burst(1'b1, 1, base, 1'b1, acks, csf);
            burst(1'b1, 1, base, 1'b0, acks, csf);
            repeat (4) @(negedge clk);
            check(last_gap == int'(c_neg) + 2, "R9 release gap", last_gap, int'(c_neg) + 2);
        end

        // R7: tightest read, words back to back, one sample cycle at end
        c_cs = 0; c_as = 0; c_w1 = 0; c_pw = 0; c_dd = 0; c_neg = 0;
        base = 16'h0F00; clear_meas();
        burst(1'b0, 8, base, 1'b0, acks, csf);
        repeat (20) @(negedge clk);
        check(n_cs == 9, "R7 no inter-word sample", n_cs, 9);
        check(n_rv == 8 && n_dbad == 0, "R7 read words", n_rv, 8);

        finish_run();
    end

endmodule